// File: doc/BRIEF.md
# Configurable Lane Multiply-Accumulate Stage

This block is one stage of a vector datapath. It works on a set of signed fixed-point lanes, eight by default. Each lane multiplies an X operand by a Z operand, or by the constant one. The product can be forced to its magnitude. The stage then either adds the product to that lane's incoming accumulator or subtracts it, and the result saturates to the accumulator width. In place of the sum, the stage can keep the smaller or the larger of the accumulator and the signed product, and it sets a flag for each lane that reports whether the accumulator was kept.

The direction of each lane comes from two inputs combined. A pattern mode gives the base direction: add everywhere, subtract everywhere, or alternate between the two, starting with either one on the even lanes. A per-lane mask then flips that base direction. Interleaved complex data (real, imaginary, real, imaginary, ...) can therefore be given different signs on its real and imaginary parts, which is how conjugate products are formed. A product-only control treats the incoming accumulator as zero. Each request is a single valid strobe with all its operands, and the result is registered one cycle later.

Top module: `lane_mac_stage`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` was low in the previous cycle, `res_lanes` and `cmp_flags` keep their values.
- R2: While `rst` is high at a clock edge (synchronous, active high), `out_valid`, `res_lanes` and `cmp_flags` become zero after that edge.
- R3: When `use_ones` is 1, every lane uses the value 1 in place of its Z operand.
- R4: When `take_abs` is 1, the magnitude of the product is used before the sign of the lane is applied.
- R5: `add_mode` sets the base direction of each lane: 0 adds on all lanes, 1 subtracts on all lanes, 2 adds on even lanes and subtracts on odd lanes, 3 subtracts on even lanes and adds on odd lanes.
- R6: Bit i of `neg_mask` inverts the base direction of lane i. A lane subtracts when its base bit XOR its mask bit is 1, and the signed term is then the negated product.
- R7: With `cmp_mode` 0, and also with the spare code 3, each lane outputs accumulator plus signed term, saturated to the signed range of AW bits, and `cmp_flags` is zero.
- R8: With `cmp_mode` 1, each lane outputs the smaller of accumulator and signed term. The lane's flag is 1 only when the accumulator is strictly smaller; on a tie the term is output and the flag is 0.
- R9: With `cmp_mode` 2, each lane outputs the larger of accumulator and signed term. The lane's flag is 1 when the accumulator is greater than or equal to the term.
- R10: When `prod_only` is 1, each lane uses zero in place of its accumulator input, in every compare mode.
- R11: Lane i takes its operands from bits [i*XW +: XW] of `x_lanes` and `z_lanes` and from bits [i*AW +: AW] of `acc_lanes`, and writes bits [i*AW +: AW] of `res_lanes`. Lanes do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| x_lanes | input | LANES*XW | Signed X operands, lane i at [i*XW +: XW] |
| z_lanes | input | LANES*XW | Signed Z operands |
| acc_lanes | input | LANES*AW | Signed accumulator inputs |
| use_ones | input | 1 | Use 1 in place of every Z operand |
| take_abs | input | 1 | Use the magnitude of the product |
| prod_only | input | 1 | Treat accumulator inputs as zero |
| add_mode | input | 2 | Base direction pattern (R5) |
| neg_mask | input | LANES | Per-lane direction inversion |
| cmp_mode | input | 2 | 0 sum, 1 minimum, 2 maximum, 3 sum |
| out_valid | output | 1 | Result registered from the previous valid cycle |
| res_lanes | output | LANES*AW | Signed lane results |
| cmp_flags | output | LANES | Per-lane accumulator-kept flags |

## Verification
The lane assertions take it for granted that AW leaves at least two bits of headroom over the double-width product. Under that condition the signed term always fits in the accumulator width, and the bounds on minimum and maximum compare values that have the same width. The stimulus keeps XW at 8 and AW at 20, and it drives the controls with known values on every valid cycle, so no unknown control value reaches a lane. The sweep passes through every add mode, compare mode including the spare code, mask pattern and option combination. It places accumulators close to both saturation limits so that the clamp is reached in both directions.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    typedef enum logic [1:0] {
        AM_ADD    = 2'd0,
        AM_SUB    = 2'd1,
        AM_ADDSUB = 2'd2,
        AM_SUBADD = 2'd3
    } add_mode_e;

    typedef enum logic [1:0] {
        CM_SUM = 2'd0,
        CM_MIN = 2'd1,
        CM_MAX = 2'd2,
        CM_RSV = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic      use_ones;
        logic      take_abs;
        logic      prod_only;
        cmp_mode_e cmp;
    } lane_ctrl_t;

    // Base direction of a lane before its mask bit: 1 means subtract.
    function automatic logic base_sub(add_mode_e mode, int unsigned lane);
        case (mode)
            AM_ADD:    return 1'b0;
            AM_SUB:    return 1'b1;
            AM_ADDSUB: return lane[0];
            default:   return ~lane[0];
        endcase
    endfunction

endpackage

// File: rtl/lmac_sign_plan.sv
module lmac_sign_plan
    import lmac_pkg::*;
#(
    parameter int LANES = 8
) (
    input  add_mode_e        mode,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] sub_vec
);

    for (genvar i = 0; i < LANES; i++) begin : g_dir
        assign sub_vec[i] = base_sub(mode, i) ^ mask[i];
    end

endmodule

// File: rtl/lmac_lane.sv
module lmac_lane
    import lmac_pkg::*;
#(
    parameter int XW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [XW-1:0] x,
    input  logic signed [XW-1:0] z,
    input  logic signed [AW-1:0] acc,
    input  lane_ctrl_t           ctrl,
    input  logic                 sub,
    output logic signed [AW-1:0] res,
    output logic                 flag
);

    localparam int PW = 2 * XW;
    localparam int TW = PW + 2;
    localparam logic signed [AW-1:0] SAT_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_MIN = {1'b1, {(AW-1){1'b0}}};

    logic signed [XW-1:0] z_eff;
    logic signed [PW-1:0] prod;
    logic signed [TW-1:0] mag;
    logic signed [TW-1:0] term;
    logic signed [AW-1:0] term_w;
    logic signed [AW-1:0] a_eff;
    logic signed [AW:0]   sum;
    logic signed [AW-1:0] sum_sat;

    always_comb begin
        z_eff  = ctrl.use_ones ? {{(XW-1){1'b0}}, 1'b1} : z;
        prod   = x * z_eff;
        mag    = {{2{prod[PW-1]}}, prod};
        if (ctrl.take_abs && prod[PW-1])
            mag = -mag;
        term   = sub ? -mag : mag;
        term_w = {{(AW-TW){term[TW-1]}}, term};
        a_eff  = ctrl.prod_only ? '0 : acc;
        sum    = {a_eff[AW-1], a_eff} + {term_w[AW-1], term_w};
        if (sum[AW] != sum[AW-1])
            sum_sat = sum[AW] ? SAT_MIN : SAT_MAX;
        else
            sum_sat = sum[AW-1:0];

        case (ctrl.cmp)
            CM_MIN: begin
                flag = (a_eff < term_w);
                res  = flag ? a_eff : term_w;
            end
            CM_MAX: begin
                flag = (a_eff >= term_w);
                res  = flag ? a_eff : term_w;
            end
            default: begin
                flag = 1'b0;
                res  = sum_sat;
            end
        endcase
    end

    p_min_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp == CM_MIN) |-> (res <= a_eff && res <= term_w));

    p_max_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp == CM_MAX) |-> (res >= a_eff && res >= term_w));

    p_flag_pick_r8: assert property (@(posedge clk) disable iff (rst)
        flag |-> (res == a_eff));

    p_flag_sum_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp == CM_SUM || ctrl.cmp == CM_RSV) |-> !flag);

endmodule

// File: rtl/lane_mac_stage.sv
module lane_mac_stage
    import lmac_pkg::*;
#(
    parameter int LANES = 8,
    parameter int XW    = 8,
    parameter int AW    = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [LANES*XW-1:0] x_lanes,
    input  logic [LANES*XW-1:0] z_lanes,
    input  logic [LANES*AW-1:0] acc_lanes,
    input  logic                use_ones,
    input  logic                take_abs,
    input  logic                prod_only,
    input  logic [1:0]          add_mode,
    input  logic [LANES-1:0]    neg_mask,
    input  logic [1:0]          cmp_mode,
    output logic                out_valid,
    output logic [LANES*AW-1:0] res_lanes,
    output logic [LANES-1:0]    cmp_flags
);

    lane_ctrl_t          ctrl;
    logic [LANES-1:0]    sub_vec;
    logic [LANES*AW-1:0] res_d;
    logic [LANES-1:0]    flag_d;

    assign ctrl = '{use_ones:  use_ones,
                    take_abs:  take_abs,
                    prod_only: prod_only,
                    cmp:       cmp_mode_e'(cmp_mode)};

    lmac_sign_plan #(.LANES(LANES)) u_plan (
        .mode    (add_mode_e'(add_mode)),
        .mask    (neg_mask),
        .sub_vec (sub_vec)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lmac_lane #(.XW(XW), .AW(AW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .x    (x_lanes[i*XW +: XW]),
            .z    (z_lanes[i*XW +: XW]),
            .acc  (acc_lanes[i*AW +: AW]),
            .ctrl (ctrl),
            .sub  (sub_vec[i]),
            .res  (res_d[i*AW +: AW]),
            .flag (flag_d[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_lanes <= '0;
            cmp_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_lanes <= res_d;
                cmp_flags <= flag_d;
            end
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_lanes) && $stable(cmp_flags)));

    p_sum_no_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (cmp_mode == 2'd0 || cmp_mode == 2'd3)) |=> (cmp_flags == '0));

    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> (!out_valid && res_lanes == '0 && cmp_flags == '0));

endmodule

// File: tb/tb_lane_mac_stage.sv
module tb_lane_mac_stage;

    localparam int LANES = 8;
    localparam int XW    = 8;
    localparam int AW    = 20;
    localparam int MAXV  = (1 << (AW-1)) - 1;
    localparam int MINV  = -(1 << (AW-1));

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [LANES*XW-1:0] x_lanes = '0;
    logic [LANES*XW-1:0] z_lanes = '0;
    logic [LANES*AW-1:0] acc_lanes = '0;
    logic                use_ones = 1'b0;
    logic                take_abs = 1'b0;
    logic                prod_only = 1'b0;
    logic [1:0]          add_mode = 2'd0;
    logic [LANES-1:0]    neg_mask = '0;
    logic [1:0]          cmp_mode = 2'd0;
    logic                out_valid;
    logic [LANES*AW-1:0] res_lanes;
    logic [LANES-1:0]    cmp_flags;

    int checks = 0;
    int errors = 0;
    int xs [LANES];
    int zs [LANES];
    int as [LANES];
    int exp_r [LANES];
    logic [LANES-1:0] exp_f;

    always #5 clk = ~clk;

    lane_mac_stage #(.LANES(LANES), .XW(XW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_lanes(x_lanes), .z_lanes(z_lanes), .acc_lanes(acc_lanes),
        .use_ones(use_ones), .take_abs(take_abs), .prod_only(prod_only),
        .add_mode(add_mode), .neg_mask(neg_mask), .cmp_mode(cmp_mode),
        .out_valid(out_valid), .res_lanes(res_lanes), .cmp_flags(cmp_flags)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int lane_res(int i);
        return $signed(res_lanes[i*AW +: AW]);
    endfunction

    // Model built from R3..R10.
    task automatic model();
        for (int i = 0; i < LANES; i++) begin
            int  p, a, s;
            bit  sub;
            p = xs[i] * (use_ones ? 1 : zs[i]);
            if (take_abs && p < 0) p = -p;
            case (add_mode)
                2'd0: sub = 1'b0;
                2'd1: sub = 1'b1;
                2'd2: sub = (i % 2 == 1);
                default: sub = (i % 2 == 0);
            endcase
            sub = sub ^ neg_mask[i];
            if (sub) p = -p;
            a = prod_only ? 0 : as[i];
            exp_f[i] = 1'b0;
            if (cmp_mode == 2'd1) begin
                exp_f[i] = (a < p);
                exp_r[i] = exp_f[i] ? a : p;
            end else if (cmp_mode == 2'd2) begin
                exp_f[i] = (a >= p);
                exp_r[i] = exp_f[i] ? a : p;
            end else begin
                s = a + p;
                exp_r[i] = (s > MAXV) ? MAXV : (s < MINV) ? MINV : s;
            end
        end
    endtask

    task automatic pack();
        for (int i = 0; i < LANES; i++) begin
            x_lanes[i*XW +: XW]   = xs[i][XW-1:0];
            z_lanes[i*XW +: XW]   = zs[i][XW-1:0];
            acc_lanes[i*AW +: AW] = as[i][AW-1:0];
        end
    endtask

    // Drive one valid cycle at a falling edge, check at the next falling edge.
    task automatic apply(string tag);
        @(negedge clk);
        pack();
        model();
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 valid", int'(out_valid), 1);
        for (int i = 0; i < LANES; i++)
            check($sformatf("%s lane %0d", tag, i), lane_res(i), exp_r[i]);
        check({tag, " flags"}, int'(cmp_flags), int'(exp_f));
        in_valid = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < LANES; i++) begin
            xs[i] = $signed(XW'($urandom()));
            zs[i] = $signed(XW'($urandom()));
            as[i] = $signed(AW'($urandom()));
        end
        as[0] = MAXV - 5;
        as[1] = MINV + 5;
        as[2] = 0;
        xs[3] = -128; zs[3] = -128;
    endtask

    initial begin
        #(100000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 valid", int'(out_valid), 0);
        check("R2 res", int'(res_lanes == '0), 1);
        check("R2 flags", int'(cmp_flags), 0);
        rst = 1'b0;

        // R3: ones replaces Z
        for (int i = 0; i < LANES; i++) begin xs[i] = i*7 - 20; zs[i] = 99; as[i] = 10; end
        use_ones = 1'b1;
        apply("R3");
        check("R3 lane4 direct", lane_res(4), 18);
        use_ones = 1'b0;

        // R4: magnitude of negative product
        for (int i = 0; i < LANES; i++) begin xs[i] = -3; zs[i] = 5; as[i] = 0; end
        take_abs = 1'b1;
        apply("R4");
        check("R4 lane0 direct", lane_res(0), 15);
        take_abs = 1'b0;

        // R5: alternating add/subtract, even lanes add
        for (int i = 0; i < LANES; i++) begin xs[i] = 2; zs[i] = 3; as[i] = 100; end
        add_mode = 2'd2;
        apply("R5");
        check("R5 lane0 add", lane_res(0), 106);
        check("R5 lane1 sub", lane_res(1), 94);

        // R6: mask inverts lane 1 back to add
        neg_mask = 8'h02;
        apply("R6");
        check("R6 lane1 inverted", lane_res(1), 106);
        neg_mask = '0; add_mode = 2'd0;

        // R1: idle cycles hold results
        @(negedge clk);
        @(negedge clk);
        check("R1 idle valid", int'(out_valid), 0);
        check("R1 idle hold", lane_res(1), 106);

        // R10: product only in max mode
        for (int i = 0; i < LANES; i++) begin xs[i] = -4; zs[i] = 4; as[i] = 500; end
        prod_only = 1'b1; cmp_mode = 2'd2;
        apply("R10");
        check("R10 lane2 zero acc wins", lane_res(2), 0);
        prod_only = 1'b0;

        // R8: tie in min mode outputs term, flag clear
        for (int i = 0; i < LANES; i++) begin xs[i] = 5; zs[i] = 5; as[i] = 25; end
        cmp_mode = 2'd1;
        apply("R8 tie");
        check("R8 tie flags", int'(cmp_flags), 0);
        cmp_mode = 2'd2;
        apply("R9 tie");
        check("R9 tie flags", int'(cmp_flags), 8'hFF);
        cmp_mode = 2'd0;

        // R11: only lane 5 active
        for (int i = 0; i < LANES; i++) begin xs[i] = 0; zs[i] = 0; as[i] = 0; end
        xs[5] = 9; zs[5] = -7;
        apply("R11");
        check("R11 lane5", lane_res(5), -63);
        check("R11 lane4", lane_res(4), 0);

        // R7/R8/R9 with R5, R6, R3, R4, R10 combined: full control sweep
        for (int am = 0; am < 4; am++)
            for (int cm = 0; cm < 4; cm++)
                for (int opt = 0; opt < 8; opt++)
                    for (int mk = 0; mk < 3; mk++) begin
                        string tag;
                        add_mode  = am[1:0];
                        cmp_mode  = cm[1:0];
                        use_ones  = opt[0];
                        take_abs  = opt[1];
                        prod_only = opt[2];
                        neg_mask  = (mk == 0) ? 8'h00 : (mk == 1) ? 8'hA5 : 8'hFF;
                        tag = (cm == 1) ? "R8 sweep" : (cm == 2) ? "R9 sweep" : "R7 sweep";
                        fill_random();
                        apply(tag);
                    end

        // R7: saturation at both ends
        for (int i = 0; i < LANES; i++) begin xs[i] = 127; zs[i] = 127; as[i] = MAXV - 10; end
        add_mode = 2'd0; cmp_mode = 2'd0; neg_mask = '0;
        use_ones = 1'b0; take_abs = 1'b0; prod_only = 1'b0;
        apply("R7 sat high");
        check("R7 sat high direct", lane_res(0), MAXV);
        for (int i = 0; i < LANES; i++) as[i] = MINV + 10;
        add_mode = 2'd1;
        apply("R7 sat low");
        check("R7 sat low direct", lane_res(7), MINV);

        // R2: reset in mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R2 rerun valid", int'(out_valid), 0);
        check("R2 rerun res", int'(res_lanes == '0), 1);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule